// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Tracker

This block keeps, for each processor, which interrupt is being serviced and at what priority. A processor takes an interrupt with an acknowledge request: the tracker compares the highest-pending ID, which an external selector supplies, against the running priority. It either activates that interrupt and returns its ID, or returns the spurious ID 1023. A processor retires an interrupt with an end-of-interrupt (EOI) request that carries a written data word.

Nesting is kept as a linked chain. Each interrupt has one predecessor entry per processor, and that entry names the interrupt it preempted. Completing the running interrupt steps back one link. Completing an interrupt deeper in the chain walks the links one per clock and splices it out, and the processor stays busy while the walk runs. The tracker does not own pending state. It emits a clear pulse on acknowledge and a re-pend pulse on completion, and the pending store applies them.

Top module: `irq_ack_tracker`

## Requirements
- R1: After reset every processor has running ID 1023, running priority 0x100, busy low, and no response, clear or re-pend pulse; every predecessor entry holds 1023.
- R2: An accepted acknowledge whose highest-pending ID is 1023, is out of range, or has a priority not strictly below the running priority responds with ID 1023 one cycle later. It leaves running ID and priority unchanged and emits no clear pulse.
- R3: An accepted acknowledge that qualifies responds with that ID one cycle later. The ID becomes the running ID, its 8-bit priority becomes the running priority, and the former running ID is recorded as its predecessor.
- R4: A successful acknowledge emits a clear pulse in the response cycle carrying the ID. The all-processors flag equals the interrupt's broadcast bit (1 = one-to-many, clear for every processor; 0 = clear only the acknowledging processor).
- R5: An EOI takes its ID from bits 9:0 of the data word and ignores the upper bits. When the running ID is 1023 the EOI changes nothing and emits nothing.
- R6: An EOI with an in-range ID (not 1023) emits a re-pend pulse one cycle later, for the same processor, when the interrupt is level-sensitive (edge bit 0), enabled for that processor, has its line high, and has its target bit set for that processor.
- R7: An EOI of the running ID makes its predecessor the running ID. The running priority becomes that predecessor's priority, or 0x100 if the predecessor is 1023.
- R8: An EOI of any other ID leaves the running ID unchanged. It holds busy high for one cycle per link visited, from the running ID down to the link that points at the completed ID or to the chain end. If a matching link is found, that link is replaced by the completed ID's own predecessor.
- R9: Requests that arrive while busy are ignored. When acknowledge and EOI arrive in the same cycle, only the EOI is acted on and no acknowledge response is given.
- R10: Each processor's tracking state changes only in response to that processor's own requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_req | input | NCPU | Acknowledge request, one per processor |
| eoi_req | input | NCPU | End-of-interrupt request, one per processor |
| eoi_wdata | input | NCPU*32 | EOI data word per processor, ID in bits 9:0 |
| best_id | input | NCPU*10 | Highest-pending ID from the selector, per processor |
| irq_prio | input | NIRQ*8 | Priority byte per interrupt, lower value is more urgent |
| irq_edge | input | NIRQ | 1 = edge-triggered, 0 = level-sensitive |
| irq_bcast | input | NIRQ | 1 = one-to-many, 0 = per-processor pending |
| irq_en | input | NCPU*NIRQ | Enable bit, index cpu*NIRQ+irq |
| irq_line | input | NIRQ | Current input line level |
| irq_tgt | input | NCPU*NIRQ | Target bit, index cpu*NIRQ+irq |
| ack_vld | output | NCPU | Acknowledge response valid |
| ack_id | output | NCPU*10 | Acknowledge response ID |
| clr_vld | output | NCPU | Pending-clear pulse |
| clr_id | output | NCPU*10 | ID to clear |
| clr_all | output | NCPU | Clear for every processor |
| repend_vld | output | NCPU | Re-pend pulse for the issuing processor |
| repend_id | output | NCPU*10 | ID to re-pend |
| run_id | output | NCPU*10 | Running interrupt ID |
| run_prio | output | NCPU*9 | Running priority, 0x100 when idle |
| busy | output | NCPU | Chain walk in progress |

## Verification
A corrupted predecessor link stays invisible until the interrupts above it are retired. It then shows up as a wrong running ID or priority on the EOI that steps onto it, or as a walk whose busy length differs from the expected link count. A wrong running priority appears on the very next acknowledge, which accepts or rejects an ID the wrong way. For that reason the bench builds deep chains with strictly falling priorities, retires them both in order and out of order, and checks the running state on both processors after every request.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
    localparam int ID_W    = 10;
    localparam int PRIO_W  = 8;
    localparam int RPRIO_W = PRIO_W + 1;
    localparam int EOI_W   = 32;
    localparam logic [ID_W-1:0]    NO_IRQ     = 10'd1023;
    localparam logic [RPRIO_W-1:0] IDLE_RPRIO = 9'h100;

    typedef enum logic {
        TRK_READY = 1'b0,
        TRK_WALK  = 1'b1
    } trk_state_e;

    typedef struct packed {
        logic            vld;
        logic [ID_W-1:0] id;
        logic            all;
    } pend_op_t;

    function automatic logic [RPRIO_W-1:0] rprio_of(input logic none,
                                                    input logic [PRIO_W-1:0] p);
        return none ? IDLE_RPRIO : {1'b0, p};
    endfunction
endpackage

// File: rtl/irq_pred_table.sv
module irq_pred_table
    import irq_trk_pkg::*;
#(
    parameter int NIRQ = 64,
    localparam int IDX_W = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ID_W-1:0]  wr_val,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [ID_W-1:0]  rd_a,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [ID_W-1:0]  rd_b
);
    logic [ID_W-1:0] link_q [NIRQ];

    generate
        for (genvar g = 0; g < NIRQ; g++) begin : g_entry
            always_ff @(posedge clk) begin
                if (rst) begin
                    link_q[g] <= NO_IRQ;
                end else if (we && (int'(wr_idx) == g)) begin
                    link_q[g] <= wr_val;
                end
            end
        end
    endgenerate

    assign rd_a = (int'(rd_a_idx) < NIRQ) ? link_q[rd_a_idx] : NO_IRQ;
    assign rd_b = (int'(rd_b_idx) < NIRQ) ? link_q[rd_b_idx] : NO_IRQ;
endmodule

// File: rtl/irq_trk_cpu.sv
module irq_trk_cpu
    import irq_trk_pkg::*;
#(
    parameter int NIRQ = 64,
    localparam int IDX_W = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ack_req,
    input  logic                   eoi_req,
    input  logic [EOI_W-1:0]       eoi_wdata,
    input  logic [ID_W-1:0]        best_id,
    input  logic [NIRQ*PRIO_W-1:0] prio_flat,
    input  logic [NIRQ-1:0]        edge_cfg,
    input  logic [NIRQ-1:0]        bcast_cfg,
    input  logic [NIRQ-1:0]        en_row,
    input  logic [NIRQ-1:0]        line_lvl,
    input  logic [NIRQ-1:0]        tgt_row,
    output logic                   rsp_vld,
    output logic [ID_W-1:0]        rsp_id,
    output pend_op_t               clr_op,
    output pend_op_t               set_op,
    output logic [ID_W-1:0]        run_id_o,
    output logic [RPRIO_W-1:0]     run_prio_o,
    output logic                   busy
);
    function automatic logic [IDX_W-1:0] idx_of(input logic [ID_W-1:0] id);
        return id[IDX_W-1:0];
    endfunction

    function automatic logic in_rng(input logic [ID_W-1:0] id);
        return int'(id) < NIRQ;
    endfunction

    function automatic logic [PRIO_W-1:0] prio_of(input logic [ID_W-1:0] id);
        return in_rng(id) ? prio_flat[int'(idx_of(id))*PRIO_W +: PRIO_W] : '1;
    endfunction

    trk_state_e          state_q;
    logic [ID_W-1:0]     run_q, cur_q, tgt_q;
    logic [RPRIO_W-1:0]  rp_q;
    logic                rsp_vld_q;
    logic [ID_W-1:0]     rsp_id_q;
    pend_op_t            clr_q, set_q;

    logic [ID_W-1:0]     eoi_id, link_a, link_b;
    logic                walking, ack_go, eoi_go, eoi_act, best_ok, repend;
    logic                walk_end, walk_hit, tbl_we;
    logic [IDX_W-1:0]    tbl_widx;
    logic [ID_W-1:0]     tbl_wval;

    assign walking = (state_q == TRK_WALK);
    assign eoi_id  = eoi_wdata[ID_W-1:0];
    assign eoi_go  = eoi_req && !walking;
    assign ack_go  = ack_req && !eoi_req && !walking;
    assign eoi_act = eoi_go && (run_q != NO_IRQ);

    assign best_ok = (best_id != NO_IRQ) && in_rng(best_id) &&
                     ({1'b0, prio_of(best_id)} < rp_q);

    always_comb begin
        repend = 1'b0;
        if (eoi_act && (eoi_id != NO_IRQ) && in_rng(eoi_id)) begin
            repend = !edge_cfg[idx_of(eoi_id)] && en_row[idx_of(eoi_id)] &&
                     line_lvl[idx_of(eoi_id)] && tgt_row[idx_of(eoi_id)];
        end
    end

    assign walk_end = walking && (link_a == NO_IRQ);
    assign walk_hit = walking && (link_a != NO_IRQ) && (link_a == tgt_q);

    always_comb begin
        tbl_we   = 1'b0;
        tbl_widx = idx_of(best_id);
        tbl_wval = run_q;
        if (walk_hit) begin
            tbl_we   = 1'b1;
            tbl_widx = idx_of(cur_q);
            tbl_wval = link_b;
        end else if (ack_go && best_ok) begin
            tbl_we   = 1'b1;
        end
    end

    irq_pred_table #(.NIRQ(NIRQ)) u_links (
        .clk      (clk),
        .rst      (rst),
        .we       (tbl_we),
        .wr_idx   (tbl_widx),
        .wr_val   (tbl_wval),
        .rd_a_idx (walking ? idx_of(cur_q) : idx_of(run_q)),
        .rd_a     (link_a),
        .rd_b_idx (idx_of(tgt_q)),
        .rd_b     (link_b)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= TRK_READY;
            run_q     <= NO_IRQ;
            rp_q      <= IDLE_RPRIO;
            cur_q     <= NO_IRQ;
            tgt_q     <= NO_IRQ;
            rsp_vld_q <= 1'b0;
            rsp_id_q  <= NO_IRQ;
            clr_q     <= '{vld: 1'b0, id: NO_IRQ, all: 1'b0};
            set_q     <= '{vld: 1'b0, id: NO_IRQ, all: 1'b0};
        end else begin
            rsp_vld_q <= 1'b0;
            clr_q.vld <= 1'b0;
            set_q.vld <= 1'b0;
            if (ack_go) begin
                rsp_vld_q <= 1'b1;
                if (best_ok) begin
                    rsp_id_q <= best_id;
                    run_q    <= best_id;
                    rp_q     <= {1'b0, prio_of(best_id)};
                    clr_q    <= '{vld: 1'b1, id: best_id,
                                  all: bcast_cfg[idx_of(best_id)]};
                end else begin
                    rsp_id_q <= NO_IRQ;
                end
            end
            if (eoi_act) begin
                if (repend) begin
                    set_q <= '{vld: 1'b1, id: eoi_id, all: 1'b0};
                end
                if (eoi_id == run_q) begin
                    run_q <= link_a;
                    rp_q  <= rprio_of(link_a == NO_IRQ, prio_of(link_a));
                end else begin
                    state_q <= TRK_WALK;
                    cur_q   <= run_q;
                    tgt_q   <= eoi_id;
                end
            end
            if (walking) begin
                if (walk_end || walk_hit) begin
                    state_q <= TRK_READY;
                end else begin
                    cur_q <= link_a;
                end
            end
        end
    end

    assign rsp_vld    = rsp_vld_q;
    assign rsp_id     = rsp_id_q;
    assign clr_op     = clr_q;
    assign set_op     = set_q;
    assign run_id_o   = run_q;
    assign run_prio_o = rp_q;
    assign busy       = walking;

    // R1
    idle_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q == NO_IRQ) |-> (rp_q == IDLE_RPRIO));

    // R2
    reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld_q && rsp_id_q == NO_IRQ) |-> ($stable(run_q) && $stable(rp_q) && !clr_q.vld));

    // R3
    accept_run_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld_q && rsp_id_q != NO_IRQ) |-> (run_q == rsp_id_q && clr_q.vld && clr_q.id == rsp_id_q));

    // R8
    walk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        walking |-> $stable(run_q));

    // R9
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (walking && (ack_req || eoi_req)) |=> (!rsp_vld_q && !set_q.vld));

    // R9
    dual_req_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_req && eoi_req) |=> !rsp_vld_q);

    // R5
    eoi_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_req && !walking && run_q == NO_IRQ) |=> (run_q == NO_IRQ && !walking && !set_q.vld));

    // R6
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_vld_q, set_q.vld}));
endmodule

// File: rtl/irq_ack_tracker.sv
module irq_ack_tracker
    import irq_trk_pkg::*;
#(
    parameter int NCPU = 2,
    parameter int NIRQ = 64
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NCPU-1:0]        ack_req,
    input  logic [NCPU-1:0]        eoi_req,
    input  logic [NCPU*32-1:0]     eoi_wdata,
    input  logic [NCPU*10-1:0]     best_id,
    input  logic [NIRQ*8-1:0]      irq_prio,
    input  logic [NIRQ-1:0]        irq_edge,
    input  logic [NIRQ-1:0]        irq_bcast,
    input  logic [NCPU*NIRQ-1:0]   irq_en,
    input  logic [NIRQ-1:0]        irq_line,
    input  logic [NCPU*NIRQ-1:0]   irq_tgt,
    output logic [NCPU-1:0]        ack_vld,
    output logic [NCPU*10-1:0]     ack_id,
    output logic [NCPU-1:0]        clr_vld,
    output logic [NCPU*10-1:0]     clr_id,
    output logic [NCPU-1:0]        clr_all,
    output logic [NCPU-1:0]        repend_vld,
    output logic [NCPU*10-1:0]     repend_id,
    output logic [NCPU*10-1:0]     run_id,
    output logic [NCPU*9-1:0]      run_prio,
    output logic [NCPU-1:0]        busy
);
    generate
        for (genvar c = 0; c < NCPU; c++) begin : g_cpu
            pend_op_t clr_w, set_w;

            irq_trk_cpu #(.NIRQ(NIRQ)) u_trk (
                .clk        (clk),
                .rst        (rst),
                .ack_req    (ack_req[c]),
                .eoi_req    (eoi_req[c]),
                .eoi_wdata  (eoi_wdata[c*EOI_W +: EOI_W]),
                .best_id    (best_id[c*ID_W +: ID_W]),
                .prio_flat  (irq_prio),
                .edge_cfg   (irq_edge),
                .bcast_cfg  (irq_bcast),
                .en_row     (irq_en[c*NIRQ +: NIRQ]),
                .line_lvl   (irq_line),
                .tgt_row    (irq_tgt[c*NIRQ +: NIRQ]),
                .rsp_vld    (ack_vld[c]),
                .rsp_id     (ack_id[c*ID_W +: ID_W]),
                .clr_op     (clr_w),
                .set_op     (set_w),
                .run_id_o   (run_id[c*ID_W +: ID_W]),
                .run_prio_o (run_prio[c*RPRIO_W +: RPRIO_W]),
                .busy       (busy[c])
            );

            assign clr_vld[c]                = clr_w.vld;
            assign clr_id[c*ID_W +: ID_W]    = clr_w.id;
            assign clr_all[c]                = clr_w.all;
            assign repend_vld[c]             = set_w.vld;
            assign repend_id[c*ID_W +: ID_W] = set_w.id;

            // R4
            clr_range_chk: assert property (@(posedge clk) disable iff (rst)
                clr_w.vld |-> (int'(clr_w.id) < NIRQ));
        end
    endgenerate
endmodule

// File: tb/sim_irq_ack_tracker.sv
module sim_irq_ack_tracker;
    localparam int NCPU = 2;
    localparam int NIRQ = 64;
    localparam int NONE = 1023;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                  rst;
    logic [NCPU-1:0]       ack_req, eoi_req;
    logic [NCPU*32-1:0]    eoi_wdata;
    logic [NCPU*10-1:0]    best_id;
    logic [NIRQ*8-1:0]     irq_prio;
    logic [NIRQ-1:0]       irq_edge, irq_bcast, irq_line;
    logic [NCPU*NIRQ-1:0]  irq_en, irq_tgt;
    logic [NCPU-1:0]       ack_vld, clr_vld, clr_all, repend_vld, busy;
    logic [NCPU*10-1:0]    ack_id, clr_id, repend_id, run_id;
    logic [NCPU*9-1:0]     run_prio;

    irq_ack_tracker #(.NCPU(NCPU), .NIRQ(NIRQ)) u0 (
        .clk(clk), .rst(rst), .ack_req(ack_req), .eoi_req(eoi_req),
        .eoi_wdata(eoi_wdata), .best_id(best_id), .irq_prio(irq_prio),
        .irq_edge(irq_edge), .irq_bcast(irq_bcast), .irq_en(irq_en),
        .irq_line(irq_line), .irq_tgt(irq_tgt), .ack_vld(ack_vld),
        .ack_id(ack_id), .clr_vld(clr_vld), .clr_id(clr_id), .clr_all(clr_all),
        .repend_vld(repend_vld), .repend_id(repend_id), .run_id(run_id),
        .run_prio(run_prio), .busy(busy)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;
    int m_run  [NCPU];
    int m_rp   [NCPU];
    int m_pred [NCPU][NIRQ];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int prio_at(input int id);
        return int'(irq_prio[id*8 +: 8]);
    endfunction

    function automatic int d_run(input int c);
        return int'(run_id[c*10 +: 10]);
    endfunction

    function automatic int d_rp(input int c);
        return int'(run_prio[c*9 +: 9]);
    endfunction

    task automatic check_runs(input string req);
        for (int c = 0; c < NCPU; c++) begin
            chk(d_run(c) == m_run[c], {req, " run_id"}, d_run(c), m_run[c]);
            chk(d_rp(c) == m_rp[c], {req, " run_prio"}, d_rp(c), m_rp[c]);
        end
    endtask

    task automatic set_prio(input int id, input int p);
        irq_prio[id*8 +: 8] = 8'(p);
    endtask

    // R2 R3 R4: acknowledge one request on cpu c
    task automatic do_ack(input int c, input int bid);
        bit ok;
        @(negedge clk);
        best_id[c*10 +: 10] = 10'(bid);
        ack_req[c] = 1'b1;
        ok = (bid != NONE) && (bid < NIRQ) && (prio_at(bid) < m_rp[c]);
        @(negedge clk);
        ack_req[c] = 1'b0;
        chk(ack_vld[c] == 1'b1, "R3 response valid", int'(ack_vld[c]), 1);
        chk(int'(ack_id[c*10 +: 10]) == (ok ? bid : NONE), ok ? "R3 ack id" : "R2 ack id",
            int'(ack_id[c*10 +: 10]), ok ? bid : NONE);
        chk(clr_vld[c] == ok, "R4 clear pulse", int'(clr_vld[c]), int'(ok));
        if (ok) begin
            chk(int'(clr_id[c*10 +: 10]) == bid, "R4 clear id", int'(clr_id[c*10 +: 10]), bid);
            chk(clr_all[c] == irq_bcast[bid], "R4 clear all", int'(clr_all[c]), int'(irq_bcast[bid]));
            m_pred[c][bid] = m_run[c];
            m_run[c] = bid;
            m_rp[c]  = prio_at(bid);
        end
        check_runs(ok ? "R3" : "R2 R10");
    endtask

    // R5 R6 R7 R8 R9: end of interrupt on cpu c
    task automatic do_eoi(input int c, input int id, input bit poke_busy, input bit with_ack);
        bit act, rep;
        int steps, cur, nxt, n;
        @(negedge clk);
        eoi_wdata[c*32 +: 32] = {22'($urandom), 10'(id)};
        eoi_req[c] = 1'b1;
        if (with_ack) begin
            best_id[c*10 +: 10] = 10'd0;
            ack_req[c] = 1'b1;
        end
        act = (m_run[c] != NONE);
        rep = act && (id != NONE) && (id < NIRQ);
        if (rep)
            rep = !irq_edge[id] && irq_en[c*NIRQ + id] && irq_line[id] && irq_tgt[c*NIRQ + id];
        steps = 0;
        if (act && id == m_run[c]) begin
            m_run[c] = m_pred[c][id];
            m_rp[c]  = (m_run[c] == NONE) ? 256 : prio_at(m_run[c]);
        end else if (act) begin
            cur = m_run[c];
            forever begin
                steps++;
                nxt = m_pred[c][cur];
                if (nxt == NONE) break;
                if (nxt == id) begin
                    m_pred[c][cur] = m_pred[c][id];
                    break;
                end
                cur = nxt;
            end
        end
        @(negedge clk);
        eoi_req[c] = 1'b0;
        ack_req[c] = 1'b0;
        if (with_ack)
            chk(ack_vld[c] == 1'b0, "R9 ack dropped beside eoi", int'(ack_vld[c]), 0);
        chk(repend_vld[c] == rep, "R6 repend pulse", int'(repend_vld[c]), int'(rep));
        if (rep)
            chk(int'(repend_id[c*10 +: 10]) == id, "R6 repend id", int'(repend_id[c*10 +: 10]), id);
        chk(busy[c] == (steps > 0), act ? "R8 busy start" : "R5 idle eoi busy", int'(busy[c]), int'(steps > 0));
        check_runs(act ? "R7" : "R5");
        n = 0;
        while (busy[c]) begin
            n++;
            if (poke_busy && n == 1) begin
                best_id[c*10 +: 10] = 10'd0;
                ack_req[c] = 1'b1;
                eoi_req[c] = 1'b1;
            end else begin
                ack_req[c] = 1'b0;
                eoi_req[c] = 1'b0;
            end
            @(negedge clk);
            if (poke_busy && n == 1) begin
                chk(ack_vld[c] == 1'b0, "R9 ack while busy", int'(ack_vld[c]), 0);
                chk(repend_vld[c] == 1'b0, "R9 eoi while busy", int'(repend_vld[c]), 0);
            end
        end
        ack_req[c] = 1'b0;
        eoi_req[c] = 1'b0;
        if (steps > 0)
            chk(n == steps, "R8 walk length", n, steps);
        check_runs("R8");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int pick;
        int chain[$];
        void'($urandom(32'd4242));
        rst = 1'b1;
        ack_req = '0; eoi_req = '0; eoi_wdata = '0; best_id = '1;
        irq_prio = '1; irq_edge = '0; irq_bcast = '0; irq_line = '0;
        irq_en = '0; irq_tgt = '0;
        for (int c = 0; c < NCPU; c++) begin
            m_run[c] = NONE;
            m_rp[c]  = 256;
            for (int i = 0; i < NIRQ; i++) m_pred[c][i] = NONE;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_runs("R1");
        chk(busy == '0, "R1 busy", int'(busy), 0);
        chk(ack_vld == '0 && clr_vld == '0 && repend_vld == '0, "R1 pulses",
            int'({ack_vld, clr_vld, repend_vld}), 0);

        set_prio(10, 200); set_prio(20, 100); set_prio(30, 50); set_prio(40, 50);
        irq_bcast[10] = 1'b1; irq_en[10] = 1'b1; irq_line[10] = 1'b1; irq_tgt[10] = 1'b1;
        irq_edge[20] = 1'b1; irq_en[20] = 1'b1; irq_line[20] = 1'b1; irq_tgt[20] = 1'b1;
        irq_en[30] = 1'b1; irq_tgt[30] = 1'b1;
        irq_en[NIRQ + 40] = 1'b1; irq_line[40] = 1'b1; irq_tgt[NIRQ + 40] = 1'b1;

        do_eoi(0, 5, 0, 0);        // R5 idle
        do_ack(0, NONE);           // R2 spurious
        do_ack(0, 10);             // R3, R4 one-to-many
        do_ack(0, 20);             // R4 per-processor
        do_ack(0, 30);
        do_ack(0, 40);             // R2 equal priority rejected
        do_ack(1, 40);             // R10 other processor
        do_eoi(0, 10, 1, 0);       // R8 splice, R6 repend, R9 busy
        do_eoi(0, 30, 0, 0);       // R7 revert
        do_eoi(0, 20, 0, 0);       // R7 back to idle
        do_eoi(1, 40, 0, 1);       // R9 dual request, R6
        do_eoi(1, 40, 0, 0);       // R5 ignored
        do_ack(1, 90);             // R2 out of range

        for (int i = 0; i < NIRQ; i++) set_prio(i, $urandom_range(0, 255));
        irq_edge  = {$urandom, $urandom};
        irq_bcast = {$urandom, $urandom};
        irq_en    = {$urandom, $urandom, $urandom, $urandom};
        irq_tgt   = {$urandom, $urandom, $urandom, $urandom};

        for (int k = 0; k < 600; k++) begin
            int c;
            c = $urandom_range(0, NCPU - 1);
            irq_line = {$urandom, $urandom};
            if ($urandom_range(0, 1) == 0) begin
                pick = ($urandom_range(0, 7) == 0) ? NONE : $urandom_range(0, NIRQ - 1);
                do_ack(c, pick);
            end else begin
                chain.delete();
                for (int p = m_run[c]; p != NONE && chain.size() < NIRQ; p = m_pred[c][p])
                    chain.push_back(p);
                case ($urandom_range(0, 3))
                    0, 1: pick = m_run[c];
                    2: pick = (chain.size() > 0) ? chain[$urandom_range(0, chain.size() - 1)] : NONE;
                    default: pick = ($urandom_range(0, 5) == 0) ? NONE : $urandom_range(0, NIRQ - 1);
                endcase
                do_eoi(c, pick, $urandom_range(0, 3) == 0, $urandom_range(0, 7) == 0);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule